// File: doc/BRIEF.md
# Pipelined Instruction Fetch Stage with Next-PC Prediction

This block is the front end of a five-stage, 64-bit in-order processor pipeline. Every cycle it picks the address to fetch from, presents it to a byte-addressed instruction memory port, and takes back a ten-byte window starting at that address. From the window it extracts the opcode and function nibbles, the two register specifiers and the 64-bit immediate. It also works out how long the instruction is and what the next sequential address is.

The address is normally the prediction held in the fetch pipeline register. Two corrections from later stages override it. A conditional jump in the memory stage whose condition failed sends fetch back to its fall-through address. A return in writeback sends fetch to the return address it loaded. Jumps and calls are always predicted taken, so the prediction is the immediate for those two opcodes and the sequential address for every other opcode.

The decoded fields are written into the decode pipeline register. Separate stall and bubble controls let the hazard logic freeze the fetch register or freeze or flush the decode register. The later stages are not part of this block; their signals come in as plain inputs.

Top module: `fetch_stage`

## Requirements
- R1: The fetch address `imem_addr` is chosen in the same cycle with this priority: `m_vala` when `m_icode` is 7 (jump) and `m_cnd` is 0; otherwise `w_valm` when `w_icode` is 9 (return); otherwise the stored prediction.
- R2: Opcodes 2, 3, 4, 5, 6, 10 and 11 carry a register byte at window byte 1. For these opcodes `d_ra` is its upper nibble and `d_rb` its lower nibble. For any other opcode both are 0xF.
- R3: Opcodes 3, 4, 5, 7 and 8 carry a 64-bit little-endian constant. It starts at window byte 2 when a register byte is present and at window byte 1 when it is not. For any other opcode `d_valc` is 0.
- R4: `d_valp` equals the fetch address plus 1, plus 1 if a register byte is present, plus 8 if a constant is present.
- R5: The next prediction is the constant for opcodes 7 and 8 and `valP` for all others. It is stored at the clock edge and becomes the fetch address of the next cycle when no correction is active.
- R6: Window byte 0 holds the opcode in bits 7:4 and the function in bits 3:0. `d_stat` uses AOK=1, HLT=2, ADR=3 and INS=4. It is ADR when `imem_err` is high. Otherwise it is INS for an opcode above 11, and in that case `d_icode` becomes 1 and `d_ifun` becomes 0. Otherwise it is HLT for opcode 0 and AOK for everything else.
- R7: The decode register loads the decoded fields at each edge. With `d_stall` high it keeps its contents, and this takes precedence over `d_bubble`. With `d_bubble` high and no stall it loads a no-op: icode 1, ifun 0, rA and rB 0xF, valC and valP 0, status AOK.
- R8: With `f_stall` high the stored prediction keeps its value across the edge.
- R9: A synchronous active-high `rst` clears the stored prediction to 0 and loads the decode register with the no-op of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 64 | Selected fetch address |
| imem_bytes | input | 80 | Ten bytes at the fetch address, byte 0 in bits 7:0 |
| imem_err | input | 1 | Instruction memory address error |
| m_icode | input | 4 | Opcode in the memory stage |
| m_cnd | input | 1 | Condition outcome of the memory-stage instruction |
| m_vala | input | 64 | Fall-through address carried by the memory-stage jump |
| w_icode | input | 4 | Opcode in writeback |
| w_valm | input | 64 | Value loaded by the writeback instruction |
| f_stall | input | 1 | Hold the fetch register |
| d_stall | input | 1 | Hold the decode register |
| d_bubble | input | 1 | Flush the decode register to a no-op |
| d_stat | output | 3 | Decode register status |
| d_icode | output | 4 | Decode register opcode |
| d_ifun | output | 4 | Decode register function |
| d_ra | output | 4 | Decode register first register ID |
| d_rb | output | 4 | Decode register second register ID |
| d_valc | output | 64 | Decode register constant |
| d_valp | output | 64 | Decode register sequential next address |

## Verification
The fetch address has no register between it and the correction inputs, so it is due in the same cycle as the stimulus. The bench applies inputs at the falling edge and compares the address a nanosecond later. Each decoded field and each prediction is due one rising edge after the window that produced it. The bench therefore keeps a reference decode register and a reference prediction, updates them under the stall and bubble rules it applied, and compares the decode outputs at the following falling edge. The prediction is compared when it reappears as the next fetch address.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

    localparam int XLEN        = 64;
    localparam int BYTE_W      = 8;
    localparam int CONST_BYTES = XLEN / BYTE_W;
    localparam int WIN_BYTES   = 2 + CONST_BYTES;
    localparam int WIN_W       = WIN_BYTES * BYTE_W;
    localparam int NIB         = 4;

    localparam logic [NIB-1:0] OP_HALT  = 4'h0;
    localparam logic [NIB-1:0] OP_NOP   = 4'h1;
    localparam logic [NIB-1:0] OP_RRMOV = 4'h2;
    localparam logic [NIB-1:0] OP_IRMOV = 4'h3;
    localparam logic [NIB-1:0] OP_RMMOV = 4'h4;
    localparam logic [NIB-1:0] OP_MRMOV = 4'h5;
    localparam logic [NIB-1:0] OP_ALU   = 4'h6;
    localparam logic [NIB-1:0] OP_JUMP  = 4'h7;
    localparam logic [NIB-1:0] OP_CALL  = 4'h8;
    localparam logic [NIB-1:0] OP_RET   = 4'h9;
    localparam logic [NIB-1:0] OP_PUSH  = 4'hA;
    localparam logic [NIB-1:0] OP_POP   = 4'hB;

    localparam logic [NIB-1:0] REG_NONE = 4'hF;

    typedef enum logic [2:0] {
        ST_AOK = 3'd1,
        ST_HLT = 3'd2,
        ST_ADR = 3'd3,
        ST_INS = 3'd4
    } stat_e;

    typedef struct packed {
        stat_e           stat;
        logic [NIB-1:0]  icode;
        logic [NIB-1:0]  ifun;
        logic [NIB-1:0]  ra;
        logic [NIB-1:0]  rb;
        logic [XLEN-1:0] valc;
        logic [XLEN-1:0] valp;
    } dfields_t;

    function automatic logic has_regbyte(input logic [NIB-1:0] op);
        return (op == OP_RRMOV) || (op == OP_IRMOV) || (op == OP_RMMOV) ||
               (op == OP_MRMOV) || (op == OP_ALU)   || (op == OP_PUSH)  ||
               (op == OP_POP);
    endfunction

    function automatic logic has_const(input logic [NIB-1:0] op);
        return (op == OP_IRMOV) || (op == OP_RMMOV) || (op == OP_MRMOV) ||
               (op == OP_JUMP)  || (op == OP_CALL);
    endfunction

    function automatic logic goes_to_target(input logic [NIB-1:0] op);
        return (op == OP_JUMP) || (op == OP_CALL);
    endfunction

    function automatic logic is_known(input logic [NIB-1:0] op);
        return op <= OP_POP;
    endfunction

    function automatic dfields_t noop_fields();
        dfields_t f;
        f.stat  = ST_AOK;
        f.icode = OP_NOP;
        f.ifun  = '0;
        f.ra    = REG_NONE;
        f.rb    = REG_NONE;
        f.valc  = '0;
        f.valp  = '0;
        return f;
    endfunction

endpackage

// File: rtl/fetch_pc_select.sv
module fetch_pc_select
    import fetch_pkg::*;
(
    input  logic [NIB-1:0]  m_icode,
    input  logic            m_cnd,
    input  logic [XLEN-1:0] m_vala,
    input  logic [NIB-1:0]  w_icode,
    input  logic [XLEN-1:0] w_valm,
    input  logic [XLEN-1:0] pred_pc,
    output logic [XLEN-1:0] sel_pc
);
    logic branch_missed;
    logic ret_done;

    always_comb begin
        branch_missed = (m_icode == OP_JUMP) && !m_cnd;
        ret_done      = (w_icode == OP_RET);
        if (branch_missed)
            sel_pc = m_vala;
        else if (ret_done)
            sel_pc = w_valm;
        else
            sel_pc = pred_pc;
    end
endmodule

// File: rtl/fetch_decode.sv
module fetch_decode
    import fetch_pkg::*;
(
    input  logic [XLEN-1:0]  pc,
    input  logic [WIN_W-1:0] win,
    input  logic             mem_err,
    output dfields_t         fields,
    output logic [XLEN-1:0]  pred_next
);
    logic [NIB-1:0] op;
    logic [NIB-1:0] fn;
    logic           need_r;
    logic           need_c;
    logic [NIB-1:0] ilen;
    logic [XLEN-1:0] cval;
    logic [XLEN-1:0] seq;

    always_comb begin
        op     = win[BYTE_W-1 -: NIB];
        fn     = win[NIB-1:0];
        need_r = has_regbyte(op);
        need_c = has_const(op);

        ilen = 4'd1 + (need_r ? 4'd1 : 4'd0) + (need_c ? 4'(CONST_BYTES) : 4'd0);
        seq  = pc + XLEN'(ilen);

        if (!need_c)
            cval = '0;
        else if (need_r)
            cval = win[2*BYTE_W +: XLEN];
        else
            cval = win[BYTE_W +: XLEN];

        fields.icode = op;
        fields.ifun  = fn;
        fields.ra    = need_r ? win[2*BYTE_W-1 -: NIB] : REG_NONE;
        fields.rb    = need_r ? win[BYTE_W +: NIB]     : REG_NONE;
        fields.valc  = cval;
        fields.valp  = seq;

        if (mem_err) begin
            fields.stat = ST_ADR;
        end else if (!is_known(op)) begin
            fields.stat  = ST_INS;
            fields.icode = OP_NOP;
            fields.ifun  = '0;
        end else if (op == OP_HALT) begin
            fields.stat = ST_HLT;
        end else begin
            fields.stat = ST_AOK;
        end

        pred_next = goes_to_target(op) ? cval : seq;
    end
endmodule

// File: rtl/fetch_pipe_regs.sv
module fetch_pipe_regs
    import fetch_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            f_stall,
    input  logic            d_stall,
    input  logic            d_bubble,
    input  logic [XLEN-1:0] pred_next,
    input  dfields_t        d_next,
    output logic [XLEN-1:0] pred_q,
    output dfields_t        d_q
);
    always_ff @(posedge clk) begin
        if (rst)
            pred_q <= '0;
        else if (!f_stall)
            pred_q <= pred_next;
    end

    always_ff @(posedge clk) begin
        if (rst)
            d_q <= noop_fields();
        else if (d_stall)
            d_q <= d_q;
        else if (d_bubble)
            d_q <= noop_fields();
        else
            d_q <= d_next;
    end

    // R8: a stalled fetch register keeps the prediction
    a_r8_fetch_hold: assert property (@(posedge clk) disable iff (rst)
        f_stall |=> $stable(pred_q));

    // R7: stall keeps the decode register, even with a bubble request
    a_r7_decode_hold: assert property (@(posedge clk) disable iff (rst)
        d_stall |=> $stable(d_q));

    // R7: bubble without stall leaves a no-op
    a_r7_bubble_noop: assert property (@(posedge clk) disable iff (rst)
        (d_bubble && !d_stall) |=> (d_q.icode == OP_NOP && d_q.ra == REG_NONE &&
                                    d_q.rb == REG_NONE && d_q.stat == ST_AOK));
endmodule

// File: rtl/fetch_stage.sv
module fetch_stage
    import fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [XLEN-1:0]   imem_addr,
    input  logic [WIN_W-1:0]  imem_bytes,
    input  logic              imem_err,
    input  logic [NIB-1:0]    m_icode,
    input  logic              m_cnd,
    input  logic [XLEN-1:0]   m_vala,
    input  logic [NIB-1:0]    w_icode,
    input  logic [XLEN-1:0]   w_valm,
    input  logic              f_stall,
    input  logic              d_stall,
    input  logic              d_bubble,
    output logic [2:0]        d_stat,
    output logic [NIB-1:0]    d_icode,
    output logic [NIB-1:0]    d_ifun,
    output logic [NIB-1:0]    d_ra,
    output logic [NIB-1:0]    d_rb,
    output logic [XLEN-1:0]   d_valc,
    output logic [XLEN-1:0]   d_valp
);
    logic [XLEN-1:0] pred_q;
    logic [XLEN-1:0] pred_next;
    logic [XLEN-1:0] sel_pc;
    dfields_t        dec_fields;
    dfields_t        d_q;

    fetch_pc_select u_sel (
        .m_icode (m_icode),
        .m_cnd   (m_cnd),
        .m_vala  (m_vala),
        .w_icode (w_icode),
        .w_valm  (w_valm),
        .pred_pc (pred_q),
        .sel_pc  (sel_pc)
    );

    fetch_decode u_dec (
        .pc        (sel_pc),
        .win       (imem_bytes),
        .mem_err   (imem_err),
        .fields    (dec_fields),
        .pred_next (pred_next)
    );

    fetch_pipe_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .f_stall   (f_stall),
        .d_stall   (d_stall),
        .d_bubble  (d_bubble),
        .pred_next (pred_next),
        .d_next    (dec_fields),
        .pred_q    (pred_q),
        .d_q       (d_q)
    );

    assign imem_addr = sel_pc;
    assign d_stat    = d_q.stat;
    assign d_icode   = d_q.icode;
    assign d_ifun    = d_q.ifun;
    assign d_ra      = d_q.ra;
    assign d_rb      = d_q.rb;
    assign d_valc    = d_q.valc;
    assign d_valp    = d_q.valp;

    // R1: a failed memory-stage jump takes the fetch address first
    a_r1_mispredict_first: assert property (@(posedge clk) disable iff (rst)
        (m_icode == OP_JUMP && !m_cnd) |-> (imem_addr == m_vala));

    // R1: a writeback return is second in priority
    a_r1_return_second: assert property (@(posedge clk) disable iff (rst)
        (!(m_icode == OP_JUMP && !m_cnd) && w_icode == OP_RET) |-> (imem_addr == w_valm));

    // R6: an unknown opcode lands in decode as INS carrying a no-op code
    a_r6_invalid_op: assert property (@(posedge clk) disable iff (rst)
        (!d_stall && !d_bubble && !imem_err && imem_bytes[7:4] > OP_POP)
        |=> (d_stat == ST_INS && d_icode == OP_NOP));
endmodule

// File: tb/fetch_stage_bench.sv
module fetch_stage_bench;
    localparam time HALF = 2.5ns;

    typedef struct packed {
        logic [2:0]  st;
        logic [3:0]  ic;
        logic [3:0]  fn;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [63:0] vc;
        logic [63:0] vp;
    } ref_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] imem_addr;
    logic [79:0] imem_bytes = '0;
    logic        imem_err = 1'b0;
    logic [3:0]  m_icode = 4'h0;
    logic        m_cnd = 1'b0;
    logic [63:0] m_vala = '0;
    logic [3:0]  w_icode = 4'h0;
    logic [63:0] w_valm = '0;
    logic        f_stall = 1'b0;
    logic        d_stall = 1'b0;
    logic        d_bubble = 1'b0;
    logic [2:0]  d_stat;
    logic [3:0]  d_icode, d_ifun, d_ra, d_rb;
    logic [63:0] d_valc, d_valp;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    ref_t exp_d;
    logic [63:0] exp_pred;

    always #HALF clk = ~clk;

    fetch_stage u_fetch_stage (
        .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_bytes(imem_bytes),
        .imem_err(imem_err), .m_icode(m_icode), .m_cnd(m_cnd), .m_vala(m_vala),
        .w_icode(w_icode), .w_valm(w_valm), .f_stall(f_stall), .d_stall(d_stall),
        .d_bubble(d_bubble), .d_stat(d_stat), .d_icode(d_icode), .d_ifun(d_ifun),
        .d_ra(d_ra), .d_rb(d_rb), .d_valc(d_valc), .d_valp(d_valp)
    );

    function automatic ref_t ref_noop();
        ref_t r;
        r = '0;
        r.st = 3'd1; r.ic = 4'h1; r.ra = 4'hF; r.rb = 4'hF;
        return r;
    endfunction

    function automatic bit ref_regs(input logic [3:0] op);
        case (op)
            4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic bit ref_imm(input logic [3:0] op);
        case (op)
            4'h3, 4'h4, 4'h5, 4'h7, 4'h8: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic ref_t ref_decode(input logic [63:0] pc, input logic [79:0] b,
                                        input logic err);
        ref_t r;
        logic [3:0] op;
        op   = b[7:4];
        r.ic = op;
        r.fn = b[3:0];
        r.ra = ref_regs(op) ? b[15:12] : 4'hF;
        r.rb = ref_regs(op) ? b[11:8]  : 4'hF;
        r.vc = !ref_imm(op) ? 64'd0 : (ref_regs(op) ? b[79:16] : b[71:8]);
        r.vp = pc + 64'd1 + (ref_regs(op) ? 64'd1 : 64'd0) + (ref_imm(op) ? 64'd8 : 64'd0);
        if (err) r.st = 3'd3;
        else if (op > 4'hB) begin r.st = 3'd4; r.ic = 4'h1; r.fn = 4'h0; end
        else if (op == 4'h0) r.st = 3'd2;
        else r.st = 3'd1;
        return r;
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] got,
                       input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic check_d(input string base);
        string hold;
        hold = base;
        chk(hold == "" ? "R6" : hold, "d_stat",  64'(d_stat),  64'(exp_d.st));
        chk(hold == "" ? "R6" : hold, "d_icode", 64'(d_icode), 64'(exp_d.ic));
        chk(hold == "" ? "R6" : hold, "d_ifun",  64'(d_ifun),  64'(exp_d.fn));
        chk(hold == "" ? "R2" : hold, "d_ra",    64'(d_ra),    64'(exp_d.ra));
        chk(hold == "" ? "R2" : hold, "d_rb",    64'(d_rb),    64'(exp_d.rb));
        chk(hold == "" ? "R3" : hold, "d_valc",  d_valc,       exp_d.vc);
        chk(hold == "" ? "R4" : hold, "d_valp",  d_valp,       exp_d.vp);
    endtask

    // Inputs are already set at a falling edge; runs one full cycle.
    task automatic step(input string addr_req);
        logic [63:0] sel;
        ref_t        dec;
        string       dreq;
        #1;
        if (m_icode == 4'h7 && !m_cnd) sel = m_vala;
        else if (w_icode == 4'h9)      sel = w_valm;
        else                           sel = exp_pred;
        chk(addr_req, "imem_addr", imem_addr, sel);
        dec = ref_decode(sel, imem_bytes, imem_err);
        if (!f_stall)
            exp_pred = (imem_bytes[7:4] == 4'h7 || imem_bytes[7:4] == 4'h8) ? dec.vc : dec.vp;
        dreq = (d_stall || d_bubble) ? "R7" : "";
        if (!d_stall) exp_d = d_bubble ? ref_noop() : dec;
        @(posedge clk);
        @(negedge clk);
        check_d(dreq);
    endtask

    task automatic quiet();
        m_icode = 4'h0; m_cnd = 1'b0; w_icode = 4'h0;
        f_stall = 1'b0; d_stall = 1'b0; d_bubble = 1'b0; imem_err = 1'b0;
    endtask

    initial begin
        #(HALF * 2 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed_f00d);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_pred = 64'd0;
        exp_d    = ref_noop();
        // R9: reset state
        check_d("R9");
        quiet();
        imem_bytes = 80'h10;                         // nop at 0
        step("R9");
        imem_bytes = {64'h1122334455667788, 8'hF3, 8'h30};  // irmov, regs + const
        step("R5");
        imem_bytes = {8'h00, 64'h400, 8'h70};        // jump to 0x400
        step("R5");
        imem_bytes = {8'h00, 64'h800, 8'h80};        // call to 0x800
        step("R5");
        m_icode = 4'h7; m_cnd = 1'b0; m_vala = 64'h123;
        w_icode = 4'h9; w_valm = 64'h999;            // both corrections: jump wins
        imem_bytes = 80'h90;
        step("R1");
        m_icode = 4'h7; m_cnd = 1'b1;                // taken jump: return used
        imem_bytes = 80'h00;                         // halt
        step("R1");
        quiet();
        imem_bytes = {64'hAAAA, 8'h12, 8'hC5};       // unknown opcode
        step("R5");
        imem_err = 1'b1;
        imem_bytes = {64'h0, 8'h4F, 8'hA0};          // push with address error
        step("R6");
        quiet();
        f_stall = 1'b1;
        imem_bytes = {8'h00, 64'h5000, 8'h70};       // jump while fetch stalled
        step("R5");
        f_stall = 1'b0;
        d_stall = 1'b1; d_bubble = 1'b1;             // stall beats bubble
        imem_bytes = {64'h0, 8'h12, 8'h60};
        step("R8");
        d_stall = 1'b0;                              // bubble alone
        imem_bytes = {64'h0, 8'h34, 8'h20};
        step("R7");
        quiet();
        for (int i = 0; i < 2000; i++) begin
            logic [79:0] b;
            b = {16'($urandom), $urandom, $urandom};
            b[7:4] = 4'($urandom_range(0, 15));
            imem_bytes = b;
            imem_err = ($urandom_range(0, 15) == 0);
            m_icode  = ($urandom_range(0, 7) == 0) ? 4'h7 : 4'($urandom_range(0, 15));
            m_cnd    = 1'($urandom);
            m_vala   = {$urandom, $urandom};
            w_icode  = ($urandom_range(0, 7) == 0) ? 4'h9 : 4'($urandom_range(0, 15));
            w_valm   = {$urandom, $urandom};
            f_stall  = ($urandom_range(0, 7) == 0);
            d_stall  = ($urandom_range(0, 7) == 0);
            d_bubble = ($urandom_range(0, 7) == 0);
            step("R1");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule